// File: doc/BRIEF.md
# Coin Meter and Slot Lockout Command Decoder

This block turns 8-bit command bytes, written one per strobe by a small control processor, into meter pulses and coin-slot lockout levels. Each accepted command can bump a mechanical meter, lock or release one slot, or lock or release several slots at once. Meter pulses last one clock cycle. Lockout levels stay where the last command left them.

Two command tables are built in, and `table_sel` chooses between them. The standard table (`table_sel` = 0) serves slots A, B and C on lanes 0, 1 and 2, with meters on lanes 0 and 1. The alternate table (`table_sel` = 1) drives four meter and lockout lanes (0 to 3). It suppresses every meter pulse until an arming command has been seen.

A two-state machine tracks that arming gate. In state `ST_GATED` the alternate-table meter codes are decoded but their pulses are masked. Transition `ARM` (an accepted alternate command 0x0F) moves the machine to `ST_COUNTING`. That state is left only by reset, through transition `RESET`, which returns to `ST_GATED`.

Top module: `coin_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `lock_out` is 0000 and `meter_pulse` is 0000. Reset also closes the arming gate (state `ST_GATED`).
- R2: In the standard table, code 0xED pulses lane 0 (meter A) and code 0xEE pulses lane 1 (meter B). Lanes 2 and 3 never pulse in this table.
- R3: In the standard table, code 0xE1 pulses lane 0 and sets lock lane 0. Code 0xE2 pulses lane 1 and sets lock lane 1.
- R4: In the standard table, codes 0xEC and 0x0C clear all four lock lanes. Code 0x00 sets lock lanes 0, 1 and 2 and leaves lane 3 unchanged.
- R5: In the standard table, code 0x09 clears lock lane 0, 0x0A clears lane 1 and 0x08 clears lane 2. Code 0x01 sets lane 0 and 0x02 sets lane 1.
- R6: In the standard table, codes 0xE8 and 0xE4, and every other code not named in R2 to R5, change no lock lane and pulse no meter.
- R7: In the alternate table, codes 0x08, 0x09, 0x0A and 0x0B pulse lanes 0, 2, 1 and 3 respectively, but only while the gate is in `ST_COUNTING`. In `ST_GATED` they pulse nothing.
- R8: In the alternate table, 0x0C sets lock lanes 0 and 2 and 0x0D clears them. 0x0E sets lanes 1 and 3. 0x0F clears lanes 1 and 3 and arms the gate, without pulsing any meter itself.
- R9: In the alternate table, codes other than 0x08 to 0x0F change nothing.
- R10: A command is accepted only in a cycle with `cmd_wr` high. Its meter pulse appears in the following cycle for exactly one cycle. Lock lanes change only in the cycle after an accepted command.
- R11: Once armed, the gate stays in `ST_COUNTING` regardless of later commands or of `table_sel`, until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| table_sel | input | 1 | 0 selects the standard table, 1 the alternate table |
| cmd_wr | input | 1 | Command strobe; one command per cycle high |
| cmd_byte | input | 8 | Command code |
| meter_pulse | output | 4 | One-cycle meter pulses, bit n is lane n |
| lock_out | output | 4 | Lockout levels, bit n is lane n, 1 = locked |

## Verification
The hardest situation to reach is an alternate-table meter code arriving while the gate is still closed. Reaching it takes a reset or an unarmed start, followed by alternate meter codes issued before any 0x0F. The vector walk therefore sends those codes first, then arms, then repeats them. A directed test then applies reset in the middle of a run and shows that the gate has closed again. Mixed-table sequences show that the standard global lock leaves lane 3 untouched while the standard global unlock clears it.

// File: rtl/coin_pkg.sv
package coin_pkg;

    localparam int LANES  = 4;
    localparam int LANE_A = 0;
    localparam int LANE_B = 1;
    localparam int LANE_C = 2;
    localparam int LANE_D = 3;

    typedef enum logic [0:0] {
        ST_GATED    = 1'b0,
        ST_COUNTING = 1'b1
    } gate_state_t;

    typedef struct packed {
        logic [LANES-1:0] hit;
        logic [LANES-1:0] set;
        logic [LANES-1:0] clr;
        logic             arm;
    } cmd_effect_t;

endpackage

// File: rtl/coin_std_table.sv
module coin_std_table
    import coin_pkg::*;
#(
    parameter int CMD_W = 8
) (
    input  logic [CMD_W-1:0] code,
    output cmd_effect_t      eff
);
    localparam logic [LANES-1:0] ABC = LANES'(7);

    always_comb begin
        eff = '0;
        case (code)
            CMD_W'('hED): eff.hit[LANE_A] = 1'b1;
            CMD_W'('hEE): eff.hit[LANE_B] = 1'b1;
            CMD_W'('hE1): begin
                eff.hit[LANE_A] = 1'b1;
                eff.set[LANE_A] = 1'b1;
            end
            CMD_W'('hE2): begin
                eff.hit[LANE_B] = 1'b1;
                eff.set[LANE_B] = 1'b1;
            end
            CMD_W'('hEC),
            CMD_W'('h0C): eff.clr = '1;
            CMD_W'('h00): eff.set = ABC;
            CMD_W'('h09): eff.clr[LANE_A] = 1'b1;
            CMD_W'('h0A): eff.clr[LANE_B] = 1'b1;
            CMD_W'('h08): eff.clr[LANE_C] = 1'b1;
            CMD_W'('h01): eff.set[LANE_A] = 1'b1;
            CMD_W'('h02): eff.set[LANE_B] = 1'b1;
            default:      eff = '0;
        endcase
    end
endmodule

// File: rtl/coin_alt_table.sv
module coin_alt_table
    import coin_pkg::*;
#(
    parameter int CMD_W = 8
) (
    input  logic [CMD_W-1:0] code,
    output cmd_effect_t      eff
);
    always_comb begin
        eff = '0;
        case (code)
            CMD_W'('h08): eff.hit[LANE_A] = 1'b1;
            CMD_W'('h09): eff.hit[LANE_C] = 1'b1;
            CMD_W'('h0A): eff.hit[LANE_B] = 1'b1;
            CMD_W'('h0B): eff.hit[LANE_D] = 1'b1;
            CMD_W'('h0C): begin
                eff.set[LANE_A] = 1'b1;
                eff.set[LANE_C] = 1'b1;
            end
            CMD_W'('h0D): begin
                eff.clr[LANE_A] = 1'b1;
                eff.clr[LANE_C] = 1'b1;
            end
            CMD_W'('h0E): begin
                eff.set[LANE_B] = 1'b1;
                eff.set[LANE_D] = 1'b1;
            end
            CMD_W'('h0F): begin
                eff.clr[LANE_B] = 1'b1;
                eff.clr[LANE_D] = 1'b1;
                eff.arm         = 1'b1;
            end
            default:      eff = '0;
        endcase
    end
endmodule

// File: rtl/coin_gate_fsm.sv
module coin_gate_fsm
    import coin_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm_req,
    output logic gate_open
);
    gate_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GATED:    if (arm_req) state_d = ST_COUNTING;
            ST_COUNTING: state_d = ST_COUNTING;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_GATED;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_GATED:    gate_open = 1'b0;
            ST_COUNTING: gate_open = 1'b1;
        endcase
    end
endmodule

// File: rtl/coin_cmd_decoder.sv
module coin_cmd_decoder
    import coin_pkg::*;
#(
    parameter int CMD_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             table_sel,
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_byte,
    output logic [LANES-1:0] meter_pulse,
    output logic [LANES-1:0] lock_out
);
    cmd_effect_t      std_eff, alt_eff, sel_eff;
    logic             gate_open;
    logic             arm_req;
    logic [LANES-1:0] hit_mask;

    coin_std_table #(.CMD_W(CMD_W)) u_std (.code(cmd_byte), .eff(std_eff));
    coin_alt_table #(.CMD_W(CMD_W)) u_alt (.code(cmd_byte), .eff(alt_eff));

    coin_gate_fsm u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_req  (arm_req),
        .gate_open(gate_open)
    );

    always_comb begin
        sel_eff  = table_sel ? alt_eff : std_eff;
        arm_req  = cmd_wr & table_sel & alt_eff.arm;
        hit_mask = {LANES{~table_sel | gate_open}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meter_pulse <= '0;
            lock_out    <= '0;
        end else begin
            meter_pulse <= cmd_wr ? (sel_eff.hit & hit_mask) : '0;
            if (cmd_wr)
                lock_out <= (lock_out & ~sel_eff.clr) | sel_eff.set;
        end
    end
endmodule

// File: rtl/coin_cmd_decoder_chk.sv
module coin_cmd_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       table_sel,
    input logic       cmd_wr,
    input logic [7:0] cmd_byte,
    input logic [3:0] meter_pulse,
    input logic [3:0] lock_out,
    input logic       gate_open
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (lock_out == 4'b0 && meter_pulse == 4'b0));

    p_std_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_wr) && !$past(table_sel)) |-> (meter_pulse[3:2] == 2'b0));

    p_single_meter_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(meter_pulse));

    p_ignored_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cmd_wr) && !$past(table_sel) &&
         ($past(cmd_byte) == 8'hE8 || $past(cmd_byte) == 8'hE4))
        |-> (meter_pulse == 4'b0 && $stable(lock_out)));

    p_gated_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(table_sel) && meter_pulse != 4'b0) |-> $past(gate_open));

    p_pulse_needs_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (meter_pulse != 4'b0) |-> $past(cmd_wr));

    p_lock_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cmd_wr) |-> $stable(lock_out));

    p_gate_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gate_open) |-> gate_open);
endmodule

bind coin_cmd_decoder coin_cmd_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .table_sel  (table_sel),
    .cmd_wr     (cmd_wr),
    .cmd_byte   (cmd_byte),
    .meter_pulse(meter_pulse),
    .lock_out   (lock_out),
    .gate_open  (gate_open)
);

// File: tb/coin_cmd_decoder_tb.sv
module coin_cmd_decoder_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       table_sel = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic [3:0] meter_pulse;
    logic [3:0] lock_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    coin_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .table_sel(table_sel), .cmd_wr(cmd_wr),
        .cmd_byte(cmd_byte), .meter_pulse(meter_pulse), .lock_out(lock_out)
    );

    // {req[3:0], table_sel, cmd[7:0], expected pulse[3:0], expected lock[3:0]}
    localparam int NV = 30;
    localparam logic [20:0] VEC [0:NV-1] = '{
        {4'd4,  1'b0, 8'h00, 4'b0000, 4'b0111},  // R4 global lock A,B,C
        {4'd5,  1'b0, 8'h09, 4'b0000, 4'b0110},  // R5
        {4'd5,  1'b0, 8'h0A, 4'b0000, 4'b0100},  // R5
        {4'd5,  1'b0, 8'h08, 4'b0000, 4'b0000},  // R5
        {4'd5,  1'b0, 8'h01, 4'b0000, 4'b0001},  // R5
        {4'd5,  1'b0, 8'h02, 4'b0000, 4'b0011},  // R5
        {4'd4,  1'b0, 8'h0C, 4'b0000, 4'b0000},  // R4
        {4'd2,  1'b0, 8'hED, 4'b0001, 4'b0000},  // R2
        {4'd2,  1'b0, 8'hEE, 4'b0010, 4'b0000},  // R2
        {4'd3,  1'b0, 8'hE1, 4'b0001, 4'b0001},  // R3
        {4'd3,  1'b0, 8'hE2, 4'b0010, 4'b0011},  // R3
        {4'd6,  1'b0, 8'hE8, 4'b0000, 4'b0011},  // R6
        {4'd6,  1'b0, 8'hE4, 4'b0000, 4'b0011},  // R6
        {4'd6,  1'b0, 8'h5A, 4'b0000, 4'b0011},  // R6
        {4'd4,  1'b0, 8'hEC, 4'b0000, 4'b0000},  // R4
        {4'd6,  1'b0, 8'h0B, 4'b0000, 4'b0000},  // R6
        {4'd7,  1'b1, 8'h08, 4'b0000, 4'b0000},  // R7 gated
        {4'd7,  1'b1, 8'h0B, 4'b0000, 4'b0000},  // R7 gated
        {4'd8,  1'b1, 8'h0C, 4'b0000, 4'b0101},  // R8
        {4'd8,  1'b1, 8'h0E, 4'b0000, 4'b1111},  // R8
        {4'd8,  1'b1, 8'h0D, 4'b0000, 4'b1010},  // R8
        {4'd8,  1'b1, 8'h0F, 4'b0000, 4'b0000},  // R8 arms, no pulse
        {4'd7,  1'b1, 8'h08, 4'b0001, 4'b0000},  // R7
        {4'd7,  1'b1, 8'h09, 4'b0100, 4'b0000},  // R7
        {4'd7,  1'b1, 8'h0A, 4'b0010, 4'b0000},  // R7
        {4'd7,  1'b1, 8'h0B, 4'b1000, 4'b0000},  // R7
        {4'd9,  1'b1, 8'hED, 4'b0000, 4'b0000},  // R9
        {4'd4,  1'b0, 8'h00, 4'b0000, 4'b0111},  // R4 lane 3 untouched
        {4'd11, 1'b1, 8'h0E, 4'b0000, 4'b1111},  // R11 mixed tables
        {4'd4,  1'b0, 8'h0C, 4'b0000, 4'b0000}   // R4 clears lane 3
    };

    task automatic check(input string tag, input logic [3:0] gp, input logic [3:0] ep,
                         input logic [3:0] gl, input logic [3:0] el);
        n_chk++;
        if (gp !== ep || gl !== el) begin
            n_fail++;
            $display("FAIL %s: pulse=%b lock=%b expected pulse=%b lock=%b", tag, gp, gl, ep, el);
        end
    endtask

    task automatic send(input logic sel, input logic [7:0] c);
        @(negedge clk);
        table_sel = sel;
        cmd_byte  = c;
        cmd_wr    = 1'b1;
        @(negedge clk);
        cmd_wr    = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", meter_pulse, 4'b0, lock_out, 4'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", meter_pulse, 4'b0, lock_out, 4'b0);

        for (int i = 0; i < NV; i++) begin
            send(VEC[i][16], VEC[i][15:8]);
            check($sformatf("R%0d vector %0d", VEC[i][20:17], i),
                  meter_pulse, VEC[i][7:4], lock_out, VEC[i][3:0]);
        end

        // R10: pulse lasts one cycle, lock holds
        send(1'b0, 8'hE1);
        check("R10 pulse cycle", meter_pulse, 4'b0001, lock_out, 4'b0001);
        @(negedge clk);
        check("R10 pulse ends", meter_pulse, 4'b0000, lock_out, 4'b0001);
        // R10: command without strobe ignored
        @(negedge clk);
        table_sel = 1'b0; cmd_byte = 8'h00; cmd_wr = 1'b0;
        @(negedge clk);
        check("R10 no strobe", meter_pulse, 4'b0000, lock_out, 4'b0001);
        cmd_byte = 8'hED;
        @(negedge clk);
        check("R10 no strobe meter", meter_pulse, 4'b0000, lock_out, 4'b0001);
        // R10: two-cycle strobe gives two accepted commands
        @(negedge clk);
        table_sel = 1'b1; cmd_byte = 8'h0B; cmd_wr = 1'b1;
        @(negedge clk);
        check("R10 back-to-back 1", meter_pulse, 4'b1000, lock_out, 4'b0001);
        @(negedge clk);
        cmd_wr = 1'b0;
        check("R10 back-to-back 2", meter_pulse, 4'b1000, lock_out, 4'b0001);
        @(negedge clk);
        check("R10 back-to-back end", meter_pulse, 4'b0000, lock_out, 4'b0001);

        // R11 and R1: reset in the middle closes the gate and releases locks
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", meter_pulse, 4'b0, lock_out, 4'b0);
        rst_n = 1'b1;
        send(1'b1, 8'h09);
        check("R11 gate closed by reset", meter_pulse, 4'b0000, lock_out, 4'b0000);
        send(1'b1, 8'h0F);
        send(1'b0, 8'hEC);
        send(1'b1, 8'h09);
        check("R11 gate stays open", meter_pulse, 4'b0100, lock_out, 4'b0000);

        done = 1'b1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule